// File: doc/BRIEF.md
# Rotating Byte Lane Distributor

This block sits between a host-side stream of 32-bit words and a row of byte-wide disk channels. In the write direction each accepted word is cut into four bytes, most significant byte first. The bytes form one unbroken stream and are dealt out to the channels one at a time in rotating order. In the read direction the block walks the channels in the same rotation, collects one byte per step and rebuilds whole words.

The rotation can span all nine channels, eight of them, or only channel 0. With nine lanes the word boundary and the lane boundary drift apart: a word may begin on any lane. For that reason the lane pointer carries over from one word to the next and is only cleared when a block starts. A block is opened by pulsing `start_i`. That pulse loads the lane mode, clears both lane pointers and the byte-within-word counters, and drops any partly handled word. All four edges of the block use valid/ready handshakes.

Top module: `byte_lane_router`

## Requirements
- R1: After reset no channel shows transmit valid, `rd_valid_o` is low, `wr_ready_o` is high, and only channel 0 has `ch_rx_ready_o` set.
- R2: The bytes of each accepted word leave in the order bits 31:24, 23:16, 15:8, 7:0.
- R3: With mode code 0, or with the unused code 3, byte number k of a block (counting from 0 across word boundaries) goes to channel k mod 9, so the lane pointer keeps going across words.
- R4: With mode code 1, byte k of a block goes to channel k mod 8, and channel 8 is never addressed in either direction.
- R5: With mode code 2, every byte uses channel 0 only, in both directions.
- R6: At most one channel shows transmit valid in any cycle, and transmit data is zero on every lane that is not valid.
- R7: `mode_i` is sampled only in a cycle with `start_i` high. The cycle after such a pulse shows no transmit valid and no read word, and the next byte in each direction uses channel 0. A change of `mode_i` at any other time has no effect.
- R8: In the read direction at most one channel is offered ready at a time. Bytes are taken in the same lane order as R3 to R5, and the first byte taken for a word becomes bits 31:24 of that word.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, the presented word stays on the output unchanged in the next cycle.
- R10: Any word sequence sent through the write side, with the channel bytes looped back into the read side, comes out unchanged and in order in all three modes and under backpressure.
- R11: With every handshake partner always ready, a block of N words leaves on the channels in 4·N consecutive cycles, because a new word is accepted in the cycle the last byte of the previous one leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block start: loads mode, clears pointers |
| mode_i | input | 2 | Lane mode: 0 nine lanes, 1 eight lanes, 2 one lane, 3 as 0 |
| wr_word_i | input | 32 | Host word to distribute |
| wr_valid_i | input | 1 | Host word valid |
| wr_ready_o | output | 1 | Block accepts a host word |
| ch_tx_data_o | output | 72 | Byte per channel, channel c at bits 8c+7:8c |
| ch_tx_valid_o | output | 9 | Per-channel transmit valid |
| ch_tx_ready_i | input | 9 | Per-channel transmit ready |
| ch_rx_data_i | input | 72 | Byte per channel from the disk side |
| ch_rx_valid_i | input | 9 | Per-channel receive valid |
| ch_rx_ready_o | output | 9 | Per-channel receive ready |
| rd_word_o | output | 32 | Reassembled host word |
| rd_valid_o | output | 1 | Reassembled word valid |
| rd_ready_i | input | 1 | Host takes the reassembled word |

## Verification
Each of the four mode codes is run twice over a 20-word block, once with every partner always ready and once with a stall on a different lane each cycle plus periodic read backpressure. Twenty words make 80 bytes, and 80 is not a multiple of nine. The nine-lane runs therefore show whether the lane pointer wrongly restarts at a word boundary, and the following start shows whether it is cleared when it should be. The always-ready runs separate a correct back-to-back word hand-over from one that leaves a bubble. The stalled runs separate a read side that follows the rotation from one that takes bytes off the wrong lane. Mode input changes made in the middle of a block show whether the mode is sampled anywhere other than at start.

// File: rtl/blr_pkg.sv
package blr_pkg;

    typedef enum logic [1:0] {
        MODE_ALL   = 2'd0,
        MODE_DROP1 = 2'd1,
        MODE_SOLO  = 2'd2,
        MODE_ALT   = 2'd3
    } blr_mode_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/blr_mode_ctl.sv
module blr_mode_ctl
    import blr_pkg::*;
#(
    parameter int unsigned NUM_CH = 9,
    localparam int unsigned CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    output blr_mode_e     mode_o,
    output logic [CW-1:0] last_lane_o
);

    typedef struct packed {
        blr_mode_e mode;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.mode = blr_mode_e'(mode_i);
        end
        mode_o = st_q.mode;
        unique case (st_q.mode)
            MODE_DROP1: last_lane_o = CW'(NUM_CH - 2);
            MODE_SOLO:  last_lane_o = '0;
            default:    last_lane_o = CW'(NUM_CH - 1);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_ALL};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/blr_packer.sv
module blr_packer
    import blr_pkg::*;
#(
    parameter int unsigned NUM_CH     = 9,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned IW        = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CW-1:0]     last_lane_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic [CW-1:0]     tx_lane_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i
);

    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BYTES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              full;
        logic [IW-1:0]     idx;
        logic [CW-1:0]     lane;
    } pk_state_t;

    pk_state_t st_d, st_q;
    logic      tx_fire;

    always_comb begin
        st_d       = st_q;
        tx_valid_o = st_q.full && !start_i;
        tx_fire    = tx_valid_o && tx_ready_i;
        tx_byte_o  = st_q.word[WORD_W-1 -: BYTE_W];
        tx_lane_o  = st_q.lane;
        wr_ready_o = !start_i && (!st_q.full || (tx_fire && st_q.idx == LAST_IDX));

        if (tx_fire) begin
            st_d.word = st_q.word << BYTE_W;
            st_d.lane = (st_q.lane == last_lane_i) ? '0 : st_q.lane + 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.idx  = '0;
                st_d.full = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end

        if (wr_valid_i && wr_ready_o) begin
            st_d.word = wr_word_i;
            st_d.full = 1'b1;
            st_d.idx  = '0;
        end

        if (start_i) begin
            st_d.full = 1'b0;
            st_d.idx  = '0;
            st_d.lane = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/blr_unpacker.sv
module blr_unpacker
    import blr_pkg::*;
#(
    parameter int unsigned NUM_CH     = 9,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned IW        = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CW-1:0]     last_lane_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    output logic [CW-1:0]     rx_lane_o,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i
);

    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BYTES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [IW-1:0]     idx;
        logic [CW-1:0]     lane;
        logic [WORD_W-1:0] out;
        logic              out_valid;
    } up_state_t;

    up_state_t st_d, st_q;
    logic      rx_fire;
    logic      rd_fire;

    always_comb begin
        st_d       = st_q;
        rx_lane_o  = st_q.lane;
        rd_word_o  = st_q.out;
        rd_valid_o = st_q.out_valid;
        rd_fire    = st_q.out_valid && rd_ready_i;
        rx_ready_o = !start_i &&
                     (st_q.idx != LAST_IDX || !st_q.out_valid || rd_ready_i);
        rx_fire    = rx_valid_i && rx_ready_o;

        if (rd_fire) begin
            st_d.out_valid = 1'b0;
        end

        if (rx_fire) begin
            st_d.lane = (st_q.lane == last_lane_i) ? '0 : st_q.lane + 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.out       = {st_q.acc[WORD_W-BYTE_W-1:0], rx_byte_i};
                st_d.out_valid = 1'b1;
                st_d.idx       = '0;
            end else begin
                st_d.acc = {st_q.acc[WORD_W-BYTE_W-1:0], rx_byte_i};
                st_d.idx = st_q.idx + 1'b1;
            end
        end

        if (start_i) begin
            st_d.idx       = '0;
            st_d.lane      = '0;
            st_d.out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/byte_lane_router.sv
module byte_lane_router
    import blr_pkg::*;
#(
    parameter int unsigned NUM_CH     = 9,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned LANES_W   = NUM_CH * BYTE_W,
    localparam int unsigned CW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [WORD_W-1:0]  wr_word_i,
    input  logic               wr_valid_i,
    output logic               wr_ready_o,
    output logic [LANES_W-1:0] ch_tx_data_o,
    output logic [NUM_CH-1:0]  ch_tx_valid_o,
    input  logic [NUM_CH-1:0]  ch_tx_ready_i,
    input  logic [LANES_W-1:0] ch_rx_data_i,
    input  logic [NUM_CH-1:0]  ch_rx_valid_i,
    output logic [NUM_CH-1:0]  ch_rx_ready_o,
    output logic [WORD_W-1:0]  rd_word_o,
    output logic               rd_valid_o,
    input  logic               rd_ready_i
);

    blr_mode_e         lane_mode;
    logic [CW-1:0]     last_lane;
    logic [BYTE_W-1:0] tx_byte;
    logic [CW-1:0]     tx_lane;
    logic              tx_valid;
    logic              tx_ready_sel;
    logic [BYTE_W-1:0] rx_byte_sel;
    logic              rx_valid_sel;
    logic              rx_ready;
    logic [CW-1:0]     rx_lane;

    blr_mode_ctl #(.NUM_CH(NUM_CH)) mode_ctl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .mode_o      (lane_mode),
        .last_lane_o (last_lane)
    );

    blr_packer #(.NUM_CH(NUM_CH), .WORD_BYTES(WORD_BYTES)) packer_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .last_lane_i (last_lane),
        .wr_word_i   (wr_word_i),
        .wr_valid_i  (wr_valid_i),
        .wr_ready_o  (wr_ready_o),
        .tx_byte_o   (tx_byte),
        .tx_lane_o   (tx_lane),
        .tx_valid_o  (tx_valid),
        .tx_ready_i  (tx_ready_sel)
    );

    blr_unpacker #(.NUM_CH(NUM_CH), .WORD_BYTES(WORD_BYTES)) unpacker_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .last_lane_i (last_lane),
        .rx_byte_i   (rx_byte_sel),
        .rx_valid_i  (rx_valid_sel),
        .rx_ready_o  (rx_ready),
        .rx_lane_o   (rx_lane),
        .rd_word_o   (rd_word_o),
        .rd_valid_o  (rd_valid_o),
        .rd_ready_i  (rd_ready_i)
    );

    // Select the handshake partner of the active lane in each direction.
    always_comb begin
        tx_ready_sel = 1'b0;
        rx_valid_sel = 1'b0;
        rx_byte_sel  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (tx_lane == CW'(c)) begin
                tx_ready_sel = ch_tx_ready_i[c];
            end
            if (rx_lane == CW'(c)) begin
                rx_valid_sel = ch_rx_valid_i[c];
                rx_byte_sel  = ch_rx_data_i[c*BYTE_W +: BYTE_W];
            end
        end
    end

    // Fan the single active lane out to the per-channel ports.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic hit_tx;
        assign hit_tx                             = tx_valid && (tx_lane == CW'(c));
        assign ch_tx_valid_o[c]                   = hit_tx;
        assign ch_tx_data_o[c*BYTE_W +: BYTE_W]   = hit_tx ? tx_byte : '0;
        assign ch_rx_ready_o[c]                   = rx_ready && (rx_lane == CW'(c));
    end

endmodule

// File: rtl/blr_chk.sv
module blr_chk #(
    parameter int unsigned NUM_CH     = 9,
    parameter int unsigned WORD_BYTES = 4
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic [1:0]              mode_w,
    input logic [NUM_CH-1:0]       ch_tx_valid_o,
    input logic [NUM_CH-1:0]       ch_rx_ready_o,
    input logic [WORD_BYTES*8-1:0] rd_word_o,
    input logic                    rd_valid_o,
    input logic                    rd_ready_i
);

    // R6
    one_tx_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ch_tx_valid_o));

    // R8
    one_rx_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ch_rx_ready_o));

    // R4
    narrow_top_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == 2'd1) |-> (!ch_tx_valid_o[NUM_CH-1] && !ch_rx_ready_o[NUM_CH-1]));

    // R5
    solo_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == 2'd2) |-> ((ch_tx_valid_o >> 1) == '0 && (ch_rx_ready_o >> 1) == '0));

    // R9
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_ready_i && !start_i) |=> (rd_valid_o && $stable(rd_word_o)));

    // R7
    start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (ch_tx_valid_o == '0 && !rd_valid_o));

endmodule

bind byte_lane_router blr_chk #(.NUM_CH(NUM_CH), .WORD_BYTES(WORD_BYTES)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .mode_w        (lane_mode),
    .ch_tx_valid_o (ch_tx_valid_o),
    .ch_rx_ready_o (ch_rx_ready_o),
    .rd_word_o     (rd_word_o),
    .rd_valid_o    (rd_valid_o),
    .rd_ready_i    (rd_ready_i)
);

// File: tb/byte_lane_router_tb_top.sv
module byte_lane_router_tb_top;

    localparam int NCH = 9;
    localparam int NW  = 20;
    localparam int QD  = 128;

    logic            clk = 1'b0;
    logic            rst_ni = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      mode_i = 2'd0;
    logic [31:0]     wr_word_i = '0;
    logic            wr_valid_i = 1'b0;
    logic            wr_ready_o;
    logic [NCH*8-1:0] ch_tx_data_o;
    logic [NCH-1:0]  ch_tx_valid_o;
    logic [NCH-1:0]  ch_tx_ready_i = '0;
    logic [NCH*8-1:0] ch_rx_data_i = '0;
    logic [NCH-1:0]  ch_rx_valid_i = '0;
    logic [NCH-1:0]  ch_rx_ready_o;
    logic [31:0]     rd_word_o;
    logic            rd_valid_o;
    logic            rd_ready_i = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] words [NW];
    logic [7:0]  chq [NCH][QD];
    int          qh [NCH];
    int          qt [NCH];

    always #2.5 clk = ~clk;

    byte_lane_router dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
        .wr_word_i(wr_word_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
        .ch_tx_data_o(ch_tx_data_o), .ch_tx_valid_o(ch_tx_valid_o),
        .ch_tx_ready_i(ch_tx_ready_i), .ch_rx_data_i(ch_rx_data_i),
        .ch_rx_valid_i(ch_rx_valid_i), .ch_rx_ready_o(ch_rx_ready_o),
        .rd_word_o(rd_word_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string lane_req(input int m);
        if (m == 1) return "R4";
        if (m == 2) return "R5";
        return "R3";
    endfunction

    task automatic run_block(input int m, input int pat);
        int len;
        int sent;
        int nb;
        int rcv;
        int cyc;
        int first_tx;
        int last_tx;
        bit hold_prev;
        logic [31:0] prev_word;
        len = (m == 1) ? 8 : (m == 2) ? 1 : 9;
        for (int i = 0; i < NW; i++)
            words[i] = (32'h9E3779B9 * 32'(i + 1)) ^ (32'(m) << 28) ^ 32'(pat * 32'h00F0_0F00);
        for (int c = 0; c < NCH; c++) begin qh[c] = 0; qt[c] = 0; end

        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(m);
        wr_valid_i = 1'b0; ch_rx_valid_i = '0; rd_ready_i = 1'b0; ch_tx_ready_i = '1;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = 2'(m ^ 1); // R7: must be ignored without a start pulse
        #1;
        check(ch_tx_valid_o == '0, "R7", "tx valid after start", 32'(ch_tx_valid_o), 0);
        check(!rd_valid_o, "R7", "rd valid after start", 32'(rd_valid_o), 0);
        check(ch_rx_ready_o == 9'b1, "R7", "rx ready lane 0 after start", 32'(ch_rx_ready_o), 1);

        sent = 0; nb = 0; rcv = 0; cyc = 0; first_tx = -1; last_tx = -1; hold_prev = 0; prev_word = '0;
        while (rcv < NW && cyc < 3000) begin
            wr_valid_i = (sent < NW);
            wr_word_i  = (sent < NW) ? words[sent] : '0;
            ch_tx_ready_i = (pat != 0) ? (9'h1FF ^ (9'b1 << (cyc % 9))) : 9'h1FF;
            rd_ready_i = (pat != 0) ? ((cyc % 4) != 2) : 1'b1;
            for (int c = 0; c < NCH; c++) begin
                ch_rx_valid_i[c] = (qt[c] > qh[c]);
                ch_rx_data_i[c*8 +: 8] = (qt[c] > qh[c]) ? chq[c][qh[c]] : 8'h00;
            end
            if (cyc == 5) mode_i = 2'(m ^ 2); // R7: mid-block change, ignored
            #1;
            if (hold_prev)
                check(rd_valid_o && rd_word_o == prev_word, "R9", "held word", rd_word_o, prev_word);
            check($countones(ch_tx_valid_o) <= 1, "R6", "tx lanes valid", 32'(ch_tx_valid_o), 1);
            for (int c = 0; c < NCH; c++) begin
                if (!ch_tx_valid_o[c] && ch_tx_data_o[c*8 +: 8] != 8'h00)
                    check(0, "R6", "idle lane data", 32'(ch_tx_data_o[c*8 +: 8]), 0);
                if (ch_tx_valid_o[c] && ch_tx_ready_i[c]) begin
                    logic [7:0] eb;
                    eb = 8'(words[nb / 4] >> (8 * (3 - (nb % 4))));
                    check(c == (nb % len), lane_req(m), "tx lane", 32'(c), 32'(nb % len));
                    check(ch_tx_data_o[c*8 +: 8] == eb, "R2", "tx byte", 32'(ch_tx_data_o[c*8 +: 8]), 32'(eb));
                    if (qt[c] < QD) begin chq[c][qt[c]] = ch_tx_data_o[c*8 +: 8]; qt[c]++; end
                    if (first_tx < 0) first_tx = cyc;
                    last_tx = cyc;
                    nb++;
                end
                if (ch_rx_valid_i[c] && ch_rx_ready_o[c]) qh[c]++;
            end
            if (wr_valid_i && wr_ready_o) sent++;
            hold_prev = rd_valid_o && !rd_ready_i;
            prev_word = rd_word_o;
            if (rd_valid_o && rd_ready_i) begin
                check(rd_word_o == words[rcv], "R10", "round trip word", rd_word_o, words[rcv]);
                if (rcv == 0)
                    check(rd_word_o[31:24] == words[0][31:24], "R8", "first byte to top", 32'(rd_word_o[31:24]), 32'(words[0][31:24]));
                rcv++;
            end
            @(negedge clk);
            cyc++;
        end
        check(rcv == NW, "R10", "watchdog words received", 32'(rcv), 32'(NW));
        check(nb == 4 * NW, "R2", "byte count", 32'(nb), 32'(4 * NW));
        if (pat == 0)
            check(last_tx - first_tx == 4 * NW - 1, "R11", "back-to-back span", 32'(last_tx - first_tx), 32'(4 * NW - 1));
        wr_valid_i = 1'b0; ch_rx_valid_i = '0; rd_ready_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        #1;
        check(ch_tx_valid_o == '0, "R1", "tx valid at reset", 32'(ch_tx_valid_o), 0);
        check(!rd_valid_o, "R1", "rd valid at reset", 32'(rd_valid_o), 0);
        check(wr_ready_o, "R1", "wr ready at reset", 32'(wr_ready_o), 1);
        check(ch_rx_ready_o == 9'b1, "R1", "rx ready at reset", 32'(ch_rx_ready_o), 1);
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++)
                run_block(m, p);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule